// File: doc/BRIEF.md
# Serial Concatenated Convolutional Encoder Chain

The block encodes a serial message stream in three stages. Each group of four message bits is extended by a systematic (7,4) cyclic block code into a seven-bit codeword. The codeword is then stored whole in an interleaver bank and read back in reverse slot order. The reversed stream drives a rate-1/2 feedforward convolutional encoder with constraint length 3, which emits seven two-bit symbol pairs per frame.

Message bits arrive one per accepted cycle under a valid/ready handshake. The interleaver has two banks, so a new frame can be captured while the previous one is being read out. Capture uses a one-hot slot mask: each accepted bit lands only in the slot that the mask selects. On the output side a valid strobe marks each symbol pair, and a frame-start flag marks the first pair of every frame. There is no back-pressure on the output side.

Top module: `sccc_enc`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, out_valid and out_first are 0 and in_ready is 1.
- R2: The four message bits of a frame arrive as A0, A1, A2, A3, where A0 is the first accepted bit. The parity R2 R1 R0 is the remainder of (A3x^3+A2x^2+A1x+A0)·x^3 divided by x^3+x+1.
- R3: The bits of each codeword reach the inner encoder in the order A3, A2, A1, A0, R2, R1, R0. This is the reverse of the slot order, in which R0 sits in slot 0 and A3 in slot 6.
- R4: For each input bit I, the pair is out_y1 = I xor D2 and out_y0 = out_y1 xor D1. Here D1 is the previous bit of the same frame and D2 is the bit two steps back.
- R5: D1 and D2 count as 0 at the first pair of every frame, so that pair has out_y0 = out_y1 = I. No tail bits are added.
- R6: Each accepted frame yields exactly seven valid pairs in consecutive cycles. out_first is 1 on the first of these pairs only.
- R7: When the block is idle, the first pair of a frame is valid in the second cycle after the cycle in which its fourth bit is accepted.
- R8: in_ready goes low only while both banks hold frames that have not yet been read out. A bit offered while in_ready is low is ignored.
- R9: Cycles with in_valid low do not disturb a frame that is partly captured, whatever value in_bit has in those cycles.
- R10: Under continuous input, the pairs of successive frames follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A message bit is offered |
| in_bit | input | 1 | Message bit, A0 first within a frame |
| in_ready | output | 1 | The write bank can accept a bit |
| out_valid | output | 1 | out_y0 and out_y1 carry a pair |
| out_first | output | 1 | First pair of a frame |
| out_y0 | output | 1 | Inner code output I^D1^D2 |
| out_y1 | output | 1 | Inner code output I^D2 |

## Verification
Frame capture and frame readout can coincide. The fourth bit of one frame can be written into one bank, and the bank can be swapped, in the same cycle in which the other bank delivers its last pair and is released. This is provoked by holding in_valid high across all sixteen messages back to back, and by offering deliberately inverted bits while the block is stalled. Every pair is compared against a reference that performs the polynomial division, the reversal and the convolution. The gapless run length of the stream and the fact that a stall occurred are also checked.

// File: rtl/sccc_enc.sv
module sccc_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_first,
  output logic out_y0,
  output logic out_y1
);
  localparam int N  = 7;
  localparam int K  = 4;
  localparam int P  = N - K;
  localparam int PW = $clog2(N);

  logic [N-1:0]  bank_q [2];
  logic [1:0]    full_q;
  logic          wsel_q, rsel_q;
  logic [K-1:0]  mask_q;
  logic [PW-1:0] rpos_q;
  logic          d1_q, d2_q;

  logic [K-1:0]  msg;
  logic [P-1:0]  par;
  logic          cur, d1_e, d2_e, y0, y1;

  assign in_ready = !full_q[wsel_q];

  wire take     = in_valid && in_ready;
  wire last_in  = take && mask_q[K-1];
  wire reading  = full_q[rsel_q];
  wire last_out = reading && (rpos_q == PW'(N-1));

  always_comb begin
    for (int j = 0; j < K; j++)
      msg[j] = mask_q[j] ? in_bit : bank_q[wsel_q][P+j];
  end

  assign par[0] = msg[0] ^ msg[2] ^ msg[3];
  assign par[1] = msg[0] ^ msg[1] ^ msg[2];
  assign par[2] = msg[1] ^ msg[2] ^ msg[3];

  assign cur  = bank_q[rsel_q][PW'(N-1) - rpos_q];
  assign d1_e = (rpos_q == '0) ? 1'b0 : d1_q;
  assign d2_e = (rpos_q == '0) ? 1'b0 : d2_q;
  assign y1   = cur ^ d2_e;
  assign y0   = y1 ^ d1_e;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[b] <= '0;
      end else if (take && wsel_q == 1'(b)) begin
        for (int j = 0; j < K; j++)
          if (mask_q[j]) bank_q[b][P+j] <= in_bit;
        if (last_in)
          for (int s = 0; s < P; s++) bank_q[b][s] <= par[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q    <= '0;
      wsel_q    <= 1'b0;
      rsel_q    <= 1'b0;
      mask_q    <= K'(1);
      rpos_q    <= '0;
      d1_q      <= 1'b0;
      d2_q      <= 1'b0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_y0    <= 1'b0;
      out_y1    <= 1'b0;
    end else begin
      out_valid <= reading;
      out_first <= reading && (rpos_q == '0);
      out_y0    <= y0;
      out_y1    <= y1;
      if (take) mask_q <= last_in ? K'(1) : {mask_q[K-2:0], 1'b0};
      if (last_in) wsel_q <= ~wsel_q;
      if (reading) begin
        d1_q   <= cur;
        d2_q   <= d1_e;
        rpos_q <= last_out ? '0 : rpos_q + 1'b1;
        if (last_out) rsel_q <= ~rsel_q;
      end
      for (int b = 0; b < 2; b++)
        full_q[b] <= (full_q[b] | (last_in && wsel_q == 1'(b)))
                     & ~(last_out && rsel_q == 1'(b));
    end
  end
endmodule

// File: rtl/sccc_enc_chk.sv
module sccc_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_first,
  input logic out_y0,
  input logic out_y1
);
  logic [3:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= '0;
    else if (out_first)  run_q <= 4'd1;
    else if (out_valid)  run_q <= run_q + 4'd1;
    else                 run_q <= '0;
  end

  // R6
  first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  // R5
  first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_y0 == out_y1));

  // R6
  run_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != 4'd0 && run_q < 4'd7) |-> (out_valid && !out_first));

  // R6
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> (run_q != 4'd0 && run_q < 4'd7));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_first));
endmodule

bind sccc_enc sccc_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
  .out_first(out_first), .out_y0(out_y0), .out_y1(out_y1)
);

// File: tb/tb_sccc_enc.sv
module tb_sccc_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_valid, out_first, out_y0, out_y1;

  always #5 clk = ~clk;

  sccc_enc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_first(out_first),
    .out_y0(out_y0), .out_y1(out_y1)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [1:0] exp_pair [0:511];
  logic       exp_first[0:511];
  logic [1:0] obs_pair [0:511];
  int wr_idx = 0, rd_idx = 0;
  int cyc = 0, stall_seen = 0;
  bit stream_on = 1'b0;
  int s_first = -1, s_last = -1, s_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [3:0] a);
    logic [6:0] rem;
    logic [6:0] cw;
    logic d1, d2, ib, y0, y1;
    rem = {a, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (rem[i]) rem = rem ^ (7'b0001011 << (i - 3));
    cw = {a, rem[2:0]};
    d1 = 1'b0; d2 = 1'b0;
    for (int t = 6; t >= 0; t--) begin
      ib = cw[t];
      y1 = ib ^ d2;
      y0 = ib ^ d1 ^ d2;
      exp_pair[wr_idx]  = {y0, y1};
      exp_first[wr_idx] = (t == 6);
      wr_idx++;
      d2 = d1; d1 = ib;
    end
  endtask

  task automatic send_frame(input logic [3:0] a, input int gap, input bit garbage);
    for (int b = 0; b < 4; b++) begin
      bit got = 1'b0;
      while (!got) begin
        @(negedge clk);
        in_valid = 1'b1;
        got = in_ready;
        in_bit = (!got && garbage) ? ~a[b] : a[b];
        if (!got) stall_seen++;
        @(posedge clk);
      end
      if (gap > 0 && b < 3) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_bit = ~a[b+1];
        repeat (gap - 1) @(negedge clk);
      end
    end
    push_exp(a);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (rd_idx >= wr_idx) begin
        check(1'b0, "R6 extra pair", rd_idx, wr_idx);
      end else begin
        obs_pair[rd_idx] = {out_y0, out_y1};
        check({out_y0, out_y1} == exp_pair[rd_idx], "R2/R3/R4 pair",
              {out_y0, out_y1}, exp_pair[rd_idx]);
        check(out_first == exp_first[rd_idx], "R6 first flag",
              out_first, exp_first[rd_idx]);
        rd_idx++;
      end
      if (stream_on) begin
        if (s_first < 0) s_first = cyc;
        s_last = cyc;
        s_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] lit [0:6];
    int base;
    lit[0] = 2'b11; lit[1] = 2'b01; lit[2] = 2'b01; lit[3] = 2'b00;
    lit[4] = 2'b10; lit[5] = 2'b11; lit[6] = 2'b11;

    repeat (3) @(negedge clk);
    // R1 during reset
    check(!out_valid && !out_first, "R1 reset outputs", out_valid, 0);
    check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", out_valid, 0);

    // R2 R3 R4 stated vector, plus R7 latency from idle
    base = wr_idx;
    send_frame(4'b1101, 0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 not yet valid", out_valid, 0);
    @(negedge clk);
    check(out_valid && out_first, "R7 first pair timing", out_valid, 1);
    idle_drain();
    for (int k = 0; k < 7; k++)
      check(obs_pair[base+k] == lit[k], "R4 stated vector", obs_pair[base+k], lit[k]);

    // R9: every message with idle gaps and noisy in_bit
    for (int m = 0; m < 16; m++) begin
      send_frame(4'(m), 1 + (m % 3), 1'b0);
      idle_drain();
    end

    // R8 R10: continuous stream, inverted bits offered while stalled
    stall_seen = 0;
    stream_on = 1'b1;
    for (int m = 0; m < 16; m++) send_frame(4'(15 - m), 0, 1'b1);
    idle_drain();
    stream_on = 1'b0;
    check(stall_seen > 0, "R8 stall occurred", stall_seen, 1);
    check(s_cnt == 112, "R10 pair count", s_cnt, 112);
    check(s_last - s_first + 1 == 112, "R10 no gaps", s_last - s_first + 1, 112);
    check(rd_idx == wr_idx, "R6 all pairs delivered", rd_idx, wr_idx);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule